// File: doc/BRIEF.md
# Two-Wire Bus Timeout Monitor

This block watches the clock and data lines of a two-wire serial bus, already synchronized to the system clock, and reports two fault conditions. The first is an idle bus. When both lines stay high across more than a set number of periods of the bit-rate clock source, the block reports that the bus is free. It reports this in exactly the way a STOP condition is reported: it raises a one-cycle stop-equivalent event and sets the sticky STOP flag. The second is a clock line that stays low for too long. A tick counter reloads whenever the clock line is high and advances on a slow tick while the line is low. When the count reaches its limit, it sets a sticky low-timeout flag.

Each detector has its own enable input. The interrupt request combines the free-bus event and the low-timeout flag, and the two sticky flags show which cause fired. Software acknowledges each flag by pulsing its write-one-to-clear input. Recovering the bus after a timeout is left to software.

The free detector is a state machine with four states. IDLE moves to COUNT when both lines are high. COUNT moves back to IDLE on any low line. COUNT moves to FIRE on the overflow that is one more than the limit. FIRE moves to HOLD while the lines stay high, or to IDLE otherwise. HOLD moves to IDLE on any low line. The low detector also has four states. RELOAD moves to COUNT when SCL goes low. COUNT moves back to RELOAD when SCL goes high. COUNT moves to TRIP on the limit tick. TRIP moves to EXPIRED while SCL stays low, or to RELOAD otherwise. EXPIRED moves to RELOAD when SCL goes high. Clearing an enable forces its machine back to IDLE or RELOAD.

Top module: `twb_timeout_mon`

## Requirements
- R1: With `free_en` high, `stop_evt` pulses high for one cycle in the cycle after the clock edge that samples the (FREE_PERIODS+1)-th `src_ovf` pulse. All of those pulses must be seen while `scl_i` and `sda_i` are both high. After only FREE_PERIODS such pulses there is no event.
- R2: `stop_flag` rises in the cycle after `stop_evt` and stays high until `stop_clr` is sampled high. A new event in the same cycle as the clear wins over the clear.
- R3: Any cycle in which `scl_i` or `sda_i` is sampled low discards the free-period count.
- R4: The free detector raises only one event per idle period. Further overflows while the lines stay high raise nothing until a line has gone low.
- R5: While `free_en` is low, no `stop_evt` is raised and the free count is discarded.
- R6: With `low_en` high, the low timeout trips on the LOW_TICKS-th `ms_tick` sampled while `scl_i` stays continuously low. `low_flag` rises two cycles after the clock edge that samples that tick. After LOW_TICKS-1 ticks the flag stays low.
- R7: Any cycle in which `scl_i` is sampled high reloads the low-timeout count to zero.
- R8: `low_flag` stays high until `low_clr` is sampled high, and a trip in the same cycle wins over the clear. A single low period trips at most once.
- R9: While `low_en` is low, no low timeout trips and the count is held at reload.
- R10: `irq` equals `stop_evt` OR `low_flag` at all times.
- R11: After reset, `stop_evt`, `stop_flag`, `low_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| src_ovf | input | 1 | One-cycle pulse per period of the bit-rate clock source |
| ms_tick | input | 1 | One-cycle pulse from the slow timebase (1 ms by default) |
| free_en | input | 1 | Enable for the free-bus detector |
| low_en | input | 1 | Enable for the SCL low detector |
| stop_clr | input | 1 | Write-one-to-clear for `stop_flag` |
| low_clr | input | 1 | Write-one-to-clear for `low_flag` |
| stop_evt | output | 1 | One-cycle stop-equivalent event for a free bus |
| stop_flag | output | 1 | Sticky STOP flag (cause bit for the free bus) |
| low_flag | output | 1 | Sticky low-timeout flag (cause bit for SCL low) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the low-timeout trip. It needs LOW_TICKS slow ticks while SCL is held low without a break, and the same condition must then stay in place to show that the machine does not trip again. Random line activity almost never holds SCL low for that long. The stimulus therefore drives long directed low stretches with counted ticks: one tick short of the limit, exactly at the limit, and broken by a single high cycle. The random phase keeps the lines in long runs that change rarely, so that both detectors also fire under mixed traffic. That phase also includes clears that land on the same cycle as a new event.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_COUNT = 2'd1,
        F_FIRE  = 2'd2,
        F_HOLD  = 2'd3
    } free_st_t;

    typedef enum logic [1:0] {
        L_RELOAD  = 2'd0,
        L_COUNT   = 2'd1,
        L_TRIP    = 2'd2,
        L_EXPIRED = 2'd3
    } low_st_t;

endpackage

// File: rtl/twb_free_det.sv
module twb_free_det
    import twb_pkg::*;
#(
    parameter int PERIODS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl,
    input  logic sda,
    input  logic ovf,
    output logic fire
);
    localparam int CW = $clog2(PERIODS + 2);

    free_st_t        state, nstate;
    logic [CW-1:0]   cnt, ncnt;
    logic            lines_hi;

    assign lines_hi = scl & sda;

    // Next-state and count
    always_comb begin
        nstate = state;
        ncnt   = cnt;
        if (!en) begin
            nstate = F_IDLE;
            ncnt   = '0;
        end else begin
            unique case (state)
                F_IDLE: begin
                    if (lines_hi) begin
                        nstate = F_COUNT;
                        ncnt   = ovf ? CW'(1) : '0;
                    end
                end
                F_COUNT: begin
                    if (!lines_hi) begin
                        nstate = F_IDLE;
                        ncnt   = '0;
                    end else if (ovf) begin
                        if (cnt == CW'(PERIODS)) begin
                            nstate = F_FIRE;
                            ncnt   = '0;
                        end else begin
                            ncnt = cnt + CW'(1);
                        end
                    end
                end
                F_FIRE:  nstate = lines_hi ? F_HOLD : F_IDLE;
                F_HOLD:  if (!lines_hi) nstate = F_IDLE;
                default: nstate = F_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= F_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    // Outputs
    always_comb begin
        fire = (state == F_FIRE);
    end

endmodule

// File: rtl/twb_low_det.sv
module twb_low_det
    import twb_pkg::*;
#(
    parameter int TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl,
    input  logic tick,
    output logic trip
);
    localparam int CW = $clog2(TICKS + 1);

    low_st_t         state, nstate;
    logic [CW-1:0]   cnt, ncnt;

    always_comb begin
        nstate = state;
        ncnt   = cnt;
        if (!en) begin
            nstate = L_RELOAD;
            ncnt   = '0;
        end else begin
            unique case (state)
                L_RELOAD: begin
                    ncnt = '0;
                    if (!scl) begin
                        nstate = L_COUNT;
                        ncnt   = tick ? CW'(1) : '0;
                    end
                end
                L_COUNT: begin
                    if (scl) begin
                        nstate = L_RELOAD;
                        ncnt   = '0;
                    end else if (tick) begin
                        if (cnt == CW'(TICKS - 1)) begin
                            nstate = L_TRIP;
                            ncnt   = '0;
                        end else begin
                            ncnt = cnt + CW'(1);
                        end
                    end
                end
                L_TRIP:    nstate = scl ? L_RELOAD : L_EXPIRED;
                L_EXPIRED: if (scl) nstate = L_RELOAD;
                default:   nstate = L_RELOAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= L_RELOAD;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    always_comb begin
        trip = (state == L_TRIP);
    end

endmodule

// File: rtl/twb_flags.sv
module twb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_set,
    input  logic stop_clr,
    input  logic low_set,
    input  logic low_clr,
    output logic stop_flag,
    output logic low_flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_flag <= 1'b0;
            low_flag  <= 1'b0;
        end else begin
            if (stop_set)      stop_flag <= 1'b1;
            else if (stop_clr) stop_flag <= 1'b0;
            if (low_set)       low_flag  <= 1'b1;
            else if (low_clr)  low_flag  <= 1'b0;
        end
    end

    always_comb begin
        irq = stop_set | low_flag;
    end

endmodule

// File: rtl/twb_timeout_mon.sv
module twb_timeout_mon #(
    parameter int FREE_PERIODS = 10,
    parameter int LOW_TICKS    = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic src_ovf,
    input  logic ms_tick,
    input  logic free_en,
    input  logic low_en,
    input  logic stop_clr,
    input  logic low_clr,
    output logic stop_evt,
    output logic stop_flag,
    output logic low_flag,
    output logic irq
);
    logic low_trip;

    twb_free_det #(.PERIODS(FREE_PERIODS)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (free_en),
        .scl   (scl_i),
        .sda   (sda_i),
        .ovf   (src_ovf),
        .fire  (stop_evt)
    );

    twb_low_det #(.TICKS(LOW_TICKS)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (low_en),
        .scl   (scl_i),
        .tick  (ms_tick),
        .trip  (low_trip)
    );

    twb_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_set  (stop_evt),
        .stop_clr  (stop_clr),
        .low_set   (low_trip),
        .low_clr   (low_clr),
        .stop_flag (stop_flag),
        .low_flag  (low_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/twb_timeout_chk.sv
module twb_timeout_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic free_en,
    input logic low_en,
    input logic stop_clr,
    input logic low_clr,
    input logic stop_evt,
    input logic stop_flag,
    input logic low_flag,
    input logic low_trip
);
    a_r1_evt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !stop_evt);

    a_r2_flag_follows_evt: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> stop_flag);

    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !stop_clr) |=> stop_flag);

    a_r3_low_line_blocks_evt: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_i && sda_i) |=> !stop_evt);

    a_r5_disabled_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
        !free_en |=> !stop_evt);

    a_r7_high_scl_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i |=> !low_trip);

    a_r8_low_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (low_flag && !low_clr) |=> low_flag);

    a_r8_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        low_trip |=> low_flag);

    a_r9_disabled_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        !low_en |=> !low_trip);

endmodule

bind twb_timeout_mon twb_timeout_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .free_en   (free_en),
    .low_en    (low_en),
    .stop_clr  (stop_clr),
    .low_clr   (low_clr),
    .stop_evt  (stop_evt),
    .stop_flag (stop_flag),
    .low_flag  (low_flag),
    .low_trip  (low_trip)
);

// File: tb/sim_twb_timeout_mon.sv
`timescale 1ns/1ps
module sim_twb_timeout_mon;
    localparam int FREE_N = 10;
    localparam int LOW_N  = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1, sda_i = 1'b1, src_ovf = 1'b0, ms_tick = 1'b0;
    logic free_en = 1'b0, low_en = 1'b0, stop_clr = 1'b0, low_clr = 1'b0;
    logic stop_evt, stop_flag, low_flag, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference state
    int  fcnt = 0, lcnt = 0;
    bit  fdone = 0, ldone = 0;
    bit  p_evt = 0, p_trip = 0, sflag = 0, lflag = 0;

    always #5 clk = ~clk;

    twb_timeout_mon #(.FREE_PERIODS(FREE_N), .LOW_TICKS(LOW_N)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .src_ovf(src_ovf), .ms_tick(ms_tick), .free_en(free_en),
        .low_en(low_en), .stop_clr(stop_clr), .low_clr(low_clr),
        .stop_evt(stop_evt), .stop_flag(stop_flag), .low_flag(low_flag),
        .irq(irq)
    );

    function automatic bit next_flag(bit cur, bit set, bit clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    task automatic check(string req, logic act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Reference update at the clock edge, using the inputs held there.
    task automatic model_edge();
        bit lines_hi;
        sflag = next_flag(sflag, p_evt, stop_clr);
        lflag = next_flag(lflag, p_trip, low_clr);
        lines_hi = scl_i && sda_i;
        p_evt = 0;
        if (!free_en || !lines_hi) begin
            fcnt = 0; fdone = 0;
        end else if (src_ovf && !fdone) begin
            fcnt++;
            if (fcnt == FREE_N + 1) begin p_evt = 1; fdone = 1; fcnt = 0; end
        end
        p_trip = 0;
        if (!low_en || scl_i) begin
            lcnt = 0; ldone = 0;
        end else if (ms_tick && !ldone) begin
            lcnt++;
            if (lcnt == LOW_N) begin p_trip = 1; ldone = 1; lcnt = 0; end
        end
    endtask

    task automatic compare_all();
        check("R1 R3 R4 R5 stop_evt", stop_evt, p_evt);
        check("R2 stop_flag", stop_flag, sflag);
        check("R6 R7 R8 R9 low_flag", low_flag, lflag);
        check("R10 irq", irq, p_evt | lflag);
    endtask

    // One cycle: inputs already set at negedge; model at posedge; compare at negedge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ovf_pulses(int n);
        for (int i = 0; i < n; i++) begin
            src_ovf = 1; step(); src_ovf = 0; step();
        end
    endtask

    task automatic tick_pulses(int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1; step(); ms_tick = 0; step();
        end
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 stop_evt", stop_evt, 0);
        check("R11 stop_flag", stop_flag, 0);
        check("R11 low_flag", low_flag, 0);
        check("R11 irq", irq, 0);
        rst_n = 1;
        idle(2);

        // R1: ten overflows give nothing, the eleventh fires
        free_en = 1; scl_i = 1; sda_i = 1;
        ovf_pulses(FREE_N);
        check("R1 no event after limit pulses", stop_flag, 0);
        src_ovf = 1; step(); src_ovf = 0;
        check("R1 event after limit+1", stop_evt, 1);
        step();
        check("R2 flag set", stop_flag, 1);
        // R4: more overflows while idle raise nothing new
        ovf_pulses(15);
        // R2: clear
        stop_clr = 1; step(); stop_clr = 0; step();
        check("R2 flag cleared", stop_flag, 0);

        // R3: a low blip restarts the count
        sda_i = 0; step(); sda_i = 1;
        ovf_pulses(6); sda_i = 0; step(); sda_i = 1; ovf_pulses(6);
        check("R3 no event across blip", stop_flag, 0);
        scl_i = 0; step(); scl_i = 1;

        // R5: disabled
        free_en = 0; ovf_pulses(20);
        check("R5 disabled", stop_flag, 0);

        // R6: one tick short, then the limit tick
        low_en = 1; scl_i = 0; step();
        tick_pulses(LOW_N - 1);
        check("R6 no trip one short", low_flag, 0);
        ms_tick = 1; step(); ms_tick = 0; step();
        check("R6 flag after limit", low_flag, 1);
        check("R10 irq from low flag", irq, 1);
        // R8: clear while still low, no second trip
        low_clr = 1; step(); low_clr = 0;
        tick_pulses(LOW_N + 5);
        check("R8 single trip per low period", low_flag, 0);

        // R7: a single high cycle reloads
        scl_i = 1; step(); scl_i = 0;
        tick_pulses(LOW_N - 5); scl_i = 1; step(); scl_i = 0; tick_pulses(LOW_N - 5);
        check("R7 reload on high", low_flag, 0);

        // R9: disabled
        low_en = 0; tick_pulses(LOW_N + 10);
        check("R9 disabled", low_flag, 0);
        scl_i = 1;

        // Random mix with long runs on the lines
        free_en = 1; low_en = 1;
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 59) == 0) scl_i = ~scl_i;
            if ($urandom_range(0, 49) == 0) sda_i = ~sda_i;
            src_ovf  = ($urandom_range(0, 2) == 0);
            ms_tick  = ($urandom_range(0, 1) == 0);
            stop_clr = ($urandom_range(0, 39) == 0);
            low_clr  = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 499) == 0) free_en = ~free_en;
            if ($urandom_range(0, 499) == 0) low_en = ~low_en;
            step();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule